// File: doc/BRIEF.md
# Windowed Watchdog with Pulsed Fault Output

This block supervises a processor through a single kick line. Every falling edge on the line is a kick. After a kick, the processor must stay quiet for at least a minimum spacing, and it must kick again before a maximum spacing runs out. A kick that comes too soon after the previous one is a fault. A window that runs out with no kick is also a fault. On a fault, the active-low output drops for a fixed number of cycles and then rises again. A fresh window starts when the pulse ends.

The minimum and maximum spacings are 24-bit cycle counts, given by inputs. The pulse length is the maximum spacing shifted right by three bits, with a floor of one cycle. The kick line is asynchronous, so it passes through a two-flop synchronizer before edge detection.

Timing runs only while the arm input is high and the disable input is low. In any other case the output is held high and all timers are cleared. When timing is allowed again, it starts from a clean window.

Top module: `wdw_watchdog`

## Requirements
- R1: While `rst` is high, `arm_i` is low or `wd_disable_i` is high, `fault_n_o` is 1. A cycle in which `arm_i` is low or `wd_disable_i` is high drives `fault_n_o` to 1 from the next clock edge on.
- R2: Timing begins only when `arm_i` is high and `wd_disable_i` is low. With no kick, `fault_n_o` stays 1 for exactly `slow_period_i` cycles after the first clock edge that sees the block enabled.
- R3: The kick line passes through a two-flop synchronizer. A high-to-low transition is a kick, and the design acts on it at the third rising clock edge after the input changes. A low level that is held, or a rising transition, is not a kick.
- R4: If no kick arrives within `slow_period_i` cycles of the window start, `fault_n_o` goes to 0.
- R5: A kick is early, and causes a fault, when it comes `fast_period_i` cycles or fewer after the previous kick of the same window. A spacing of `fast_period_i`+1 cycles is accepted.
- R6: Each accepted kick restarts the window. Kicks spaced anywhere from `fast_period_i`+1 to `slow_period_i` cycles apart, this last value included, never cause a fault.
- R7: A fault holds `fault_n_o` at 0 for `slow_period_i >> 3` cycles, or for 1 cycle when that shift gives zero.
- R8: A new window starts on the first cycle after the pulse. Kicks during the pulse are ignored. The first kick of a new window is never early.
- R9: Disabling or disarming the block during a pulse releases `fault_n_o` at the next edge. After re-enabling, a full `slow_period_i` window is timed from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_i | input | 1 | High once the reset controller allows supervision |
| wd_disable_i | input | 1 | High stops the watchdog |
| kick_i | input | 1 | Asynchronous kick line; falling edges count |
| fast_period_i | input | 24 | Minimum kick spacing in cycles |
| slow_period_i | input | 24 | Maximum kick spacing in cycles |
| fault_n_o | output | 1 | Active-low fault pulse |

## Verification
The assertions assume the following about the inputs:
- `fast_period_i` and `slow_period_i` do not change while the block is enabled.
- 1 ≤ `fast_period_i` < `slow_period_i`.
- `arm_i` and `wd_disable_i` are already synchronous to `clk`.

The stimulus changes the periods only while the block is disarmed, and always keeps the slow count above the fast count. It drives all inputs on falling clock edges, and holds each kick level for at least one full cycle, so the synchronizer never misses or splits an edge.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    // Width of the programmable period counts.
    localparam int unsigned PERIOD_W    = 24;
    // The fault pulse is the slow count divided by 2**PULSE_SHIFT.
    localparam int unsigned PULSE_SHIFT = 3;
    // Depth of the kick synchronizer.
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef logic [PERIOD_W-1:0] period_t;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_WATCH = 2'd1,
        WD_ALARM = 2'd2
    } wd_state_e;

    // Verdict of the window timer for the current cycle.
    typedef struct packed {
        logic early;   // kick inside the minimum spacing
        logic expire;  // maximum spacing ran out
    } win_verdict_t;

    // Fault pulse length, never shorter than one cycle.
    function automatic period_t alarm_len(period_t slow);
        period_t len;
        len = slow >> PULSE_SHIFT;
        return (len == '0) ? period_t'(1) : len;
    endfunction

endpackage

// File: rtl/wdw_kick_sync.sv
module wdw_kick_sync
    import wdw_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic kick_fell_o
);

    logic [STAGES-1:0] sync_q;
    logic              hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= 1'b1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= kick_i;
            hist_q    <= sync_q[STAGES-1];
        end
    end

    assign kick_fell_o = hist_q & ~sync_q[STAGES-1];

    // One falling transition yields exactly one event cycle.
    assert_single_event_R3: assert property (@(posedge clk) disable iff (rst)
        kick_fell_o |=> !kick_fell_o);

endmodule

// File: rtl/wdw_window_timer.sv
module wdw_window_timer
    import wdw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         run_i,
    input  logic         kick_i,
    input  period_t      fast_i,
    input  period_t      slow_i,
    output win_verdict_t verdict_o
);

    period_t elapsed_q;
    logic    seen_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            elapsed_q <= '0;
            seen_q    <= 1'b0;
        end else if (run_i) begin
            if (kick_i) begin
                elapsed_q <= '0;
                seen_q    <= 1'b1;
            end else begin
                elapsed_q <= elapsed_q + period_t'(1);
            end
        end
    end

    always_comb begin
        verdict_o.early  = run_i & kick_i & seen_q & (elapsed_q < fast_i);
        verdict_o.expire = run_i & ~kick_i & (elapsed_q >= slow_i - period_t'(1));
    end

    // While timing, the elapsed count stays inside the slow window.
    assert_window_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (elapsed_q < slow_i));

    // A cleared timer starts a new window with no prior kick.
    assert_clear_fresh_R8: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (elapsed_q == '0) && !seen_q);

endmodule

// File: rtl/wdw_alarm_timer.sv
module wdw_alarm_timer
    import wdw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run_i,
    input  period_t len_i,
    output logic    done_o
);

    period_t held_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            held_q <= '0;
        end else begin
            held_q <= held_q + period_t'(1);
        end
    end

    assign done_o = run_i & (held_q >= len_i - period_t'(1));

    // The pulse never outlasts its computed length.
    assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (held_q < len_i));

endmodule

// File: rtl/wdw_watchdog.sv
module wdw_watchdog
    import wdw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                arm_i,
    input  logic                wd_disable_i,
    input  logic                kick_i,
    input  logic [PERIOD_W-1:0] fast_period_i,
    input  logic [PERIOD_W-1:0] slow_period_i,
    output logic                fault_n_o
);

    wd_state_e    state_q;
    logic         active;
    logic         kick_evt;
    logic         pulse_done;
    win_verdict_t verdict;
    period_t      pulse_len;

    assign active    = arm_i & ~wd_disable_i;
    assign pulse_len = alarm_len(slow_period_i);

    wdw_kick_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .kick_i      (kick_i),
        .kick_fell_o (kick_evt)
    );

    wdw_window_timer u_window (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (state_q != WD_WATCH),
        .run_i     (state_q == WD_WATCH),
        .kick_i    (kick_evt),
        .fast_i    (fast_period_i),
        .slow_i    (slow_period_i),
        .verdict_o (verdict)
    );

    wdw_alarm_timer u_alarm (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state_q == WD_ALARM),
        .len_i  (pulse_len),
        .done_o (pulse_done)
    );

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            state_q <= WD_OFF;
        end else begin
            unique case (state_q)
                WD_OFF:   state_q <= WD_WATCH;
                WD_WATCH: if (verdict.early || verdict.expire) state_q <= WD_ALARM;
                WD_ALARM: if (pulse_done) state_q <= WD_WATCH;
                default:  state_q <= WD_OFF;
            endcase
        end
    end

    assign fault_n_o = (state_q != WD_ALARM);

    // Inactive cycles force the output high from the next edge.
    assert_inactive_high_R1: assert property (@(posedge clk) disable iff (rst)
        !active |=> fault_n_o);

    // Leaving the idle state never goes straight into a fault.
    assert_start_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_OFF) |=> fault_n_o);

    // Every fault has an early kick or an expired window behind it.
    assert_fault_cause_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n_o) |-> $past(verdict.early || verdict.expire));

    // The output is released only by a finished pulse or by going inactive.
    assert_release_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n_o) |-> $past(pulse_done || !active));

endmodule

// File: tb/wdw_watchdog_tb.sv
`timescale 1ns/1ps
module wdw_watchdog_tb_top;

    localparam int FAST = 20;
    localparam int SLOW = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm_i = 1'b0;
    logic        wd_disable_i = 1'b0;
    logic        kick_i = 1'b1;
    logic [23:0] fast_period_i = 24'(FAST);
    logic [23:0] slow_period_i = 24'(SLOW);
    logic        fault_n_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    wdw_watchdog dut_i (
        .clk           (clk),
        .rst           (rst),
        .arm_i         (arm_i),
        .wd_disable_i  (wd_disable_i),
        .kick_i        (kick_i),
        .fast_period_i (fast_period_i),
        .slow_period_i (slow_period_i),
        .fault_n_o     (fault_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts high samples from the current negedge until the first low one.
    task automatic count_high(output int n);
        n = 0;
        while (fault_n_o === 1'b1 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts low samples from the current negedge until the first high one.
    task automatic count_low(output int n);
        n = 0;
        while (fault_n_o === 1'b0 && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts low samples over the next n negedges.
    task automatic lows_over(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fault_n_o !== 1'b1) lows++;
        end
    endtask

    task automatic kick();
        kick_i = 1'b0;
        @(negedge clk);
        kick_i = 1'b1;
    endtask

    task automatic disarm();
        arm_i = 1'b0;
        wait_n(3);
    endtask

    task automatic t_reset();
        int lows;
        rst = 1'b1;
        wait_n(5);
        check(fault_n_o === 1'b1, "R1 reset", int'(fault_n_o), 1);
        rst = 1'b0;
        lows_over(300, lows);
        check(lows == 0, "R1 disarmed", lows, 0);
    endtask

    task automatic t_arm_timeout();
        int n;
        arm_i = 1'b1;
        @(negedge clk);
        count_high(n);
        check(n == SLOW, "R2/R4 first timeout", n, SLOW);
        count_low(n);
        check(n == SLOW / 8, "R7 pulse width", n, SLOW / 8);
        count_high(n);
        check(n == SLOW, "R8 window after pulse", n, SLOW);
        arm_i = 1'b0;
        @(negedge clk);
        check(fault_n_o === 1'b1, "R9 disarm releases", int'(fault_n_o), 1);
        wait_n(2);
    endtask

    task automatic t_held_level();
        int n;
        arm_i = 1'b1;
        wait_n(30);
        kick_i = 1'b0;
        @(negedge clk);
        fork
            begin
                wait_n(59);
                kick_i = 1'b1;
            end
            count_high(n);
        join
        check(n == SLOW + 2, "R3 fall counts, level and rise do not", n, SLOW + 2);
        disarm();
    endtask

    task automatic t_early(input int spacing, input bit expect_fault);
        int lows;
        arm_i = 1'b1;
        wait_n(30);
        kick();
        wait_n(spacing - 1);
        kick();
        @(negedge clk);
        check(fault_n_o === 1'b1, "R5 before second kick acts", int'(fault_n_o), 1);
        @(negedge clk);
        check(fault_n_o === !expect_fault, "R5 early kick boundary",
              int'(fault_n_o), int'(!expect_fault));
        if (!expect_fault) begin
            lows_over(20, lows);
            check(lows == 0, "R5 spacing fast+1 accepted", lows, 0);
        end
        disarm();
    endtask

    task automatic t_periodic();
        int lows;
        int total = 0;
        arm_i = 1'b1;
        wait_n(10);
        for (int k = 0; k < 12; k++) begin
            kick();
            lows_over(49, lows);
            total += lows;
        end
        check(total == 0, "R6 spacing 50 no fault", total, 0);
        total = 0;
        for (int k = 0; k < 3; k++) begin
            kick();
            lows_over(SLOW - 1, lows);
            total += lows;
        end
        check(total == 0, "R6 spacing equal to slow accepted", total, 0);
        disarm();
    endtask

    task automatic t_restart();
        int n;
        int lows;
        arm_i = 1'b1;
        @(negedge clk);
        count_high(n);
        wait_n(3);
        kick();
        count_low(n);
        wait_n(1);
        kick();
        lows_over(10, lows);
        check(lows == 0, "R8 pulse kick ignored, first kick not early", lows, 0);
        count_high(n);
        check(n == SLOW + 2 - 10, "R8 kick restarts new window", n, SLOW - 8);
        disarm();
    endtask

    task automatic t_disable();
        int n;
        int lows;
        arm_i = 1'b1;
        @(negedge clk);
        count_high(n);
        wait_n(2);
        wd_disable_i = 1'b1;
        @(negedge clk);
        check(fault_n_o === 1'b1, "R9 disable releases pulse", int'(fault_n_o), 1);
        lows_over(300, lows);
        check(lows == 0, "R1 disabled stays high", lows, 0);
        wd_disable_i = 1'b0;
        @(negedge clk);
        count_high(n);
        check(n == SLOW, "R9 full window after re-enable", n, SLOW);
        disarm();
    endtask

    task automatic t_pulse_len(input int fast, input int slow, input int exp_len);
        int n;
        fast_period_i = 24'(fast);
        slow_period_i = 24'(slow);
        wait_n(2);
        arm_i = 1'b1;
        @(negedge clk);
        count_high(n);
        check(n == slow, "R4 timeout with other slow count", n, slow);
        count_low(n);
        check(n == exp_len, "R7 pulse length from slow count", n, exp_len);
        disarm();
        fast_period_i = 24'(FAST);
        slow_period_i = 24'(SLOW);
        wait_n(2);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_arm_timeout();
        t_held_level();
        t_early(FAST, 1'b1);
        t_early(FAST + 1, 1'b0);
        t_periodic();
        t_restart();
        t_disable();
        t_pulse_len(2, 5, 1);
        t_pulse_len(10, 100, 12);
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL all: watchdog expired, actual 0 expected 1");
            finish_up();
        end
    end

endmodule